// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is an 8-bit down-counting watchdog. A free-running prescaler divides the system clock by 2^PRESCALE_W. It produces a slow tick, and the counter moves only on that tick. With the default divider, a 100 MHz clock gives roughly 763 ticks per second.

Software drives the block with a single control write. The write carries a count, a command and a 7-bit key. The command starts or stops the watchdog. A write is accepted only when its key is the bitwise complement of the key from the previous accepted write, so a runaway program that repeats the same write cannot keep the watchdog alive.

A start reloads the counter, so restarting and kicking the watchdog are the same operation. While the watchdog runs, the count steps down once per tick. The block sends a one-cycle non-maskable interrupt request when the count arrives at 1. It raises a chip reset when the count arrives at 0. The reset stays high until the system reset clears the block. A status port shows the count, the running flag and a sticky flag that records that an interrupt request was sent.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is released, the count is 0, the watchdog is stopped, `nmi_req`, `chip_rst` and `stat_nmi_seen` are low, and the stored key is 0, so the first key that can be accepted is 0x7F.
- R2: The prescaler steps once per clock from 0 after reset. The tick fires on the clock edge where the prescaler holds all ones, which is once in every 2^PRESCALE_W clocks. The counter changes on no other edge unless a write is accepted.
- R3: An accepted write with `wr_cmd`=1 (start) loads `wr_count` into the counter and sets the running flag. A repeated start acts as a kick.
- R4: A write is accepted only when `wr_key` equals the stored key XOR 0x7F. An accepted write stores its key.
- R5: A write with any other key changes neither the count, the running flag nor the stored key.
- R6: An accepted write with `wr_cmd`=0 (stop) clears the running flag and keeps the current count. After a stop the count does not change.
- R7: On each tick while running and not in reset, a nonzero count decreases by one.
- R8: `nmi_req` is high for exactly one clock, on the edge where the count steps from 2 to 1.
- R9: `chip_rst` rises on the tick where the count steps from 1 to 0, or on a tick while running at a count of 0. It then stays high until `rst_n` is asserted.
- R10: While `chip_rst` is high, writes are ignored and the count is frozen.
- R11: `stat_nmi_seen` rises together with `nmi_req` and stays high until `rst_n` is asserted.
- R12: When an accepted write falls on a tick edge, the write decides the new state and no decrement happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Control write strobe, one clock per write |
| wr_count | input | CNT_W | Start value loaded by a start command |
| wr_cmd | input | 1 | 1 = start/kick, 0 = stop |
| wr_key | input | KEY_W | Key that must complement the stored key |
| nmi_req | output | 1 | One-clock non-maskable interrupt request |
| chip_rst | output | 1 | Chip reset request, held until system reset |
| stat_count | output | CNT_W | Current counter value |
| stat_running | output | 1 | Watchdog is counting |
| stat_nmi_seen | output | 1 | Sticky record of an interrupt request |

## Verification
A wrong stored key stays hidden until the next write. At that point a valid write is dropped, or a stale one is taken, and the count or running flag differs from the model on the very next clock. A prescaler that is off in phase or period moves the count on the wrong edge, so the error appears within one tick period. A bad decrement shows up when `nmi_req` or `chip_rst` fires one tick early or late. The bench compares every output against its model on every clock, so each such error is reported in the first clock where it becomes visible.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W      = 8,
  parameter int KEY_W      = 7,
  parameter int PRESCALE_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_cmd,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst,
  output logic [CNT_W-1:0] stat_count,
  output logic             stat_running,
  output logic             stat_nmi_seen
);
  localparam logic [KEY_W-1:0] KEY_FLIP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

  logic [PRESCALE_W-1:0] pre_q;
  logic [KEY_W-1:0]      key_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  run_q, nmi_q, rst_q, seen_q;

  wire tick   = &pre_q;
  wire accept = wr_en && !rst_q && (wr_key == (key_q ^ KEY_FLIP));
  wire dec    = tick && run_q && !rst_q && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      key_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      nmi_q <= 1'b0;
      if (accept) begin
        key_q <= wr_key;
        run_q <= wr_cmd;
        if (wr_cmd) cnt_q <= wr_count;
      end else if (dec) begin
        if (cnt_q == '0) begin
          rst_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_TWO) begin
            nmi_q  <= 1'b1;
            seen_q <= 1'b1;
          end
          if (cnt_q == CNT_ONE) rst_q <= 1'b1;
        end
      end
    end
  end

  assign nmi_req       = nmi_q;
  assign chip_rst      = rst_q;
  assign stat_count    = cnt_q;
  assign stat_running  = run_q;
  assign stat_nmi_seen = seen_q;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W = 8,
  parameter int KEY_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_cmd,
  input logic [KEY_W-1:0] wr_key,
  input logic [KEY_W-1:0] key_q,
  input logic             nmi_req,
  input logic             chip_rst,
  input logic [CNT_W-1:0] stat_count,
  input logic             stat_running,
  input logic             stat_nmi_seen
);
  localparam logic [KEY_W-1:0] FLIP = '1;

  assert_nmi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
  assert_nmi_at_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> stat_count == CNT_W'(1));
  assert_rst_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> chip_rst);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> $stable(stat_count) && $stable(stat_running));
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_nmi_seen |=> stat_nmi_seen);
  assert_stopped_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_running && !wr_en) |=> $stable(stat_count));
  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_key != (key_q ^ FLIP)) |=> $stable(key_q) && $stable(stat_running));
  assert_good_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chip_rst && wr_key == (key_q ^ FLIP)) |=> key_q == $past(wr_key) && stat_running == $past(wr_cmd));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_key(wr_key),
  .key_q(key_q), .nmi_req(nmi_req), .chip_rst(chip_rst), .stat_count(stat_count),
  .stat_running(stat_running), .stat_nmi_seen(stat_nmi_seen)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int PW = 4;
  localparam int PERIOD = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_count = '0;
  logic       wr_cmd = 1'b0;
  logic [6:0] wr_key = '0;
  logic       nmi_req, chip_rst, stat_running, stat_nmi_seen;
  logic [7:0] stat_count;

  int vectors = 0;
  int errors = 0;

  int m_pre, m_key, m_cnt;
  bit m_run, m_nmi, m_rst, m_seen;

  always #2 clk = ~clk;

  keyed_watchdog #(.CNT_W(8), .KEY_W(7), .PRESCALE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_count(wr_count), .wr_cmd(wr_cmd),
    .wr_key(wr_key), .nmi_req(nmi_req), .chip_rst(chip_rst), .stat_count(stat_count),
    .stat_running(stat_running), .stat_nmi_seen(stat_nmi_seen)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // model of R1..R12, evaluated once per clock
  task automatic model_edge(bit we, int cnt, bit cmd, int key);
    bit tick, acc;
    if (!rst_n) begin
      m_pre = 0; m_key = 0; m_cnt = 0;
      m_run = 0; m_nmi = 0; m_rst = 0; m_seen = 0;
      return;
    end
    tick = (m_pre == PERIOD - 1);
    m_pre = (m_pre + 1) % PERIOD;
    acc = we && !m_rst && (key == (m_key ^ 127));
    m_nmi = 0;
    if (acc) begin
      m_key = key;
      m_run = cmd;
      if (cmd) m_cnt = cnt;
    end else if (tick && m_run && !m_rst) begin
      if (m_cnt == 0) m_rst = 1;
      else begin
        m_cnt--;
        if (m_cnt == 1) begin m_nmi = 1; m_seen = 1; end
        if (m_cnt == 0) m_rst = 1;
      end
    end
  endtask

  task automatic step(string tag, bit we = 0, int cnt = 0, bit cmd = 0, int key = 0);
    wr_en = we; wr_count = 8'(cnt); wr_cmd = cmd; wr_key = 7'(key);
    @(posedge clk);
    @(negedge clk);
    model_edge(we, cnt, cmd, key);
    cmp(tag, "count", int'(stat_count), m_cnt);
    cmp(tag, "running", int'(stat_running), int'(m_run));
    cmp(tag, "nmi_req", int'(nmi_req), int'(m_nmi));
    cmp(tag, "chip_rst", int'(chip_rst), int'(m_rst));
    cmp(tag, "nmi_seen", int'(stat_nmi_seen), int'(m_seen));
    wr_en = 1'b0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  int nmi_hits;

  initial begin
    rst_n = 1'b0;
    idle("R1", 3);
    rst_n = 1'b1;
    idle("R1", 4);
    // wrong first key (0 instead of 0x7F): ignored
    step("R5", 1, 5, 1, 0);
    idle("R5", 20);
    // first valid key
    step("R3", 1, 10, 1, 127);
    idle("R7", 40);
    // repeated key is now stale
    step("R5", 1, 200, 1, 127);
    idle("R2", 10);
    // align a kick with a tick edge
    while (m_pre != PERIOD - 1) step("R12");
    step("R12", 1, 9, 1, 0);
    idle("R12", 20);
    // stop holds count
    step("R6", 1, 0, 0, 127);
    idle("R6", 40);
    // start short run through NMI and reset
    step("R4", 1, 3, 1, 0);
    nmi_hits = 0;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      step("R8");
      if (nmi_req) nmi_hits++;
    end
    cmp("R8", "nmi pulses", nmi_hits, 1);
    cmp("R9", "reset held", int'(chip_rst), 1);
    cmp("R11", "sticky", int'(stat_nmi_seen), 1);
    // writes during reset are ignored
    step("R10", 1, 50, 1, 127);
    idle("R10", 20);
    // start at zero resets on next tick
    rst_n = 1'b0;
    idle("R11", 2);
    rst_n = 1'b1;
    idle("R1", 2);
    step("R9", 1, 0, 1, 127);
    idle("R9", 2 * PERIOD);
    cmp("R9", "reset from zero", int'(chip_rst), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule